// File: doc/BRIEF.md
# Transmit Byte FIFO with Low-Watermark Trigger

This block is the buffer between a bus writer and a transmitter engine. The writer pushes bytes in. The transmitter pulls them out from the head, in arrival order. A 32-bit control word holds three fields. The first is a programmable low-watermark. The block raises its trigger output whenever fewer entries are stored than this watermark, so that the writer knows to refill. The second is a synchronous flush bit, which empties the buffer on every clock edge where it is set. The third is a debug hold bit. While it is set, transmitter reads return the head byte without removing it.

Occupancy is tracked by a three-state machine. The states are OCC_EMPTY, OCC_PARTIAL and OCC_FULL. The transitions are:
- FILL: OCC_EMPTY to OCC_PARTIAL on an accepted push.
- TOP_OFF: OCC_PARTIAL to OCC_FULL on a push without a pop at depth minus one.
- DRAIN: OCC_PARTIAL to OCC_EMPTY on a pop without a push at one entry.
- RELIEVE: OCC_FULL to OCC_PARTIAL on a pop.
- FLUSH: any state to OCC_EMPTY while the flush bit is set.

Any other input combination keeps the current state. The count, the full and empty flags, and two sticky error flags are also outputs.

Top module: `tx_fifo_trig`

## Requirements
- R1: After reset the control word reads 0, count is 0, empty is 1, and full, overflow, underflow and trig are 0.
- R2: A control write stores wdata[4:0] as the watermark, wdata[16] as flush and wdata[17] as hold. On readback every other bit is 0.
- R3: The buffer holds 16 bytes in first-in-first-out order. rd_data shows the head byte combinationally in the same cycle that rd_en is high.
- R4: count gives the number of stored entries (0 to 16). full is 1 exactly when count is 16, and empty is 1 exactly when count is 0.
- R5: trig is 1 exactly when count is strictly less than the watermark. A watermark of 0 never raises trig.
- R6: On every clock edge where the stored flush bit is 1, the buffer is emptied and both sticky flags are cleared. A write in that same cycle is discarded.
- R7: Setting flush and then clearing it empties the buffer once. Later writes and reads then behave normally.
- R8: While hold is 1, a read returns the head byte and leaves the contents and count unchanged. With hold at 0, every read removes the head.
- R9: A write while full is discarded and sets overflow. overflow stays 1 until a flush.
- R10: A read while empty returns 0 and sets underflow. underflow stays 1 until a flush.
- R11: When a write and a removing read occur in the same cycle, and the buffer is neither empty nor full, both take effect and count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Control word readback |
| wr_en | input | 1 | Push request from the bus writer |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Read request from the transmitter |
| rd_data | output | 8 | Head byte, or 0 when empty |
| trig | output | 1 | Low-watermark condition |
| count | output | 5 | Number of stored entries |
| full | output | 1 | Buffer is full |
| empty | output | 1 | Buffer is empty |
| overflow | output | 1 | Sticky flag for a write while full |
| underflow | output | 1 | Sticky flag for a read while empty |

## Verification
The assertions check the following on every cycle:
- count stays in range and agrees with the full and empty flags.
- A zero watermark never triggers.
- A flush leaves an empty buffer with both sticky flags cleared.
- Hold freezes the count.
- The error flags set and stay set.
- A combined push and pop keeps the count.

Some behaviour can only be shown by the bench's scenarios:
- Data order, and the exact byte returned while hold is on.
- The trigger value over all 17 counts and all 32 watermarks.
- Normal operation resuming after a one-shot flush.
- The control word bit layout on readback.

// File: rtl/tfifo_pkg.sv
`timescale 1ns/1ps
package tfifo_pkg;
    localparam int CTL_W   = 32;
    localparam int LVL_W   = 5;
    localparam int CLR_BIT = 16;
    localparam int FRZ_BIT = 17;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    typedef struct packed {
        logic             hold;
        logic             flush;
        logic [LVL_W-1:0] level;
    } ctl_t;
endpackage

// File: rtl/tfifo_ctl_reg.sv
`timescale 1ns/1ps
module tfifo_ctl_reg
    import tfifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl,
    output logic [CTL_W-1:0] rdata
);
    logic unused_rsvd;
    assign unused_rsvd = ^{wdata[CTL_W-1:FRZ_BIT+1], wdata[CLR_BIT-1:LVL_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we) begin
            ctl.level <= wdata[LVL_W-1:0];
            ctl.flush <= wdata[CLR_BIT];
            ctl.hold  <= wdata[FRZ_BIT];
        end
    end

    always_comb begin
        rdata              = '0;
        rdata[LVL_W-1:0]   = ctl.level;
        rdata[CLR_BIT]     = ctl.flush;
        rdata[FRZ_BIT]     = ctl.hold;
    end
endmodule

// File: rtl/tfifo_store.sv
`timescale 1ns/1ps
module tfifo_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              do_push,
    input  logic              do_pop,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] head
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_nxt, rd_nxt;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/tfifo_occ_fsm.sv
`timescale 1ns/1ps
module tfifo_occ_fsm
    import tfifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             hold,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             do_push,
    output logic             do_pop,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             overflow,
    output logic             underflow
);
    occ_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = OCC_EMPTY;
        end else begin
            unique case (state)
                OCC_EMPTY: begin
                    if (do_push) state_nxt = OCC_PARTIAL;
                end
                OCC_PARTIAL: begin
                    if (do_push && !do_pop && count == CNT_W'(DEPTH - 1))
                        state_nxt = OCC_FULL;
                    else if (do_pop && !do_push && count == CNT_W'(1))
                        state_nxt = OCC_EMPTY;
                end
                OCC_FULL: begin
                    if (do_pop) state_nxt = OCC_PARTIAL;
                end
                default: state_nxt = OCC_EMPTY;
            endcase
        end
    end

    always_comb begin
        full    = (state == OCC_FULL);
        empty   = (state == OCC_EMPTY);
        do_push = wr_req && !full && !flush;
        do_pop  = rd_req && !empty && !hold && !flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (flush) begin
            count     <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (wr_req && full)  overflow  <= 1'b1;
            if (rd_req && empty) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/tx_fifo_trig.sv
`timescale 1ns/1ps
module tx_fifo_trig
    import tfifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              trig,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              overflow,
    output logic              underflow
);
    ctl_t              ctl;
    logic              do_push, do_pop;
    logic [DATA_W-1:0] head;

    tfifo_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    tfifo_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (ctl.flush),
        .hold      (ctl.hold),
        .wr_req    (wr_en),
        .rd_req    (rd_en),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .count     (count),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow),
        .underflow (underflow)
    );

    tfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (ctl.flush),
        .do_push (do_push),
        .do_pop  (do_pop),
        .wr_data (wr_data),
        .head    (head)
    );

    assign rd_data = empty ? '0 : head;
    assign trig    = (32'(count) < 32'(ctl.level));
endmodule

// File: rtl/tfifo_chk.sv
`timescale 1ns/1ps
module tfifo_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      ctl_rdata,
    input logic             wr_en,
    input logic             rd_en,
    input logic             trig,
    input logic [CNT_W-1:0] count,
    input logic             full,
    input logic             empty,
    input logic             overflow,
    input logic             underflow
);
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH);
    // R4
    empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (count == '0));
    // R4
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == (32'(count) == DEPTH));
    // R5
    zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[4:0] == 5'd0) |-> !trig);
    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[16] |=> (count == '0 && !overflow && !underflow));
    // R8
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[17] && !ctl_rdata[16] && !wr_en) |=> count == $past(count));
    // R9
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !ctl_rdata[16]) |=> overflow);
    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ctl_rdata[16]) |=> overflow);
    // R10
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !ctl_rdata[16]) |=> underflow);
    // R10
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !ctl_rdata[16]) |=> underflow);
    // R11
    push_pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && wr_en && rd_en && !ctl_rdata[17] && !ctl_rdata[16])
        |=> count == $past(count));
endmodule

bind tx_fifo_trig tfifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_tx_fifo_trig.sv
`timescale 1ns/1ps
module sim_tx_fifo_trig;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        trig;
    logic [4:0]  count;
    logic        full, empty, overflow, underflow;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tx_fifo_trig u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .trig(trig), .count(count), .full(full), .empty(empty),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic ctl_write(input logic [31:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pop(input string req, input logic [7:0] exp);
        rd_en = 1'b1;
        #1;
        chk(req, "rd_data", 32'(rd_data), 32'(exp));
        step();
        rd_en = 1'b0;
    endtask

    task automatic status(input string req, input int n);
        chk(req, "count", 32'(count), 32'(n));
        chk(req, "empty", 32'(empty), 32'(n == 0));
        chk(req, "full",  32'(full),  32'(n == 16));
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #35;
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", "ctl_rdata", ctl_rdata, 32'h0);
        status("R1", 0);
        chk("R1", "overflow", 32'(overflow), 0);
        chk("R1", "underflow", 32'(underflow), 0);
        chk("R1", "trig", 32'(trig), 0);

        // R2 field layout and reserved bits
        ctl_write(32'hFFFF_FFFF);
        chk("R2", "ctl_rdata all ones", ctl_rdata, 32'h0003_001F);
        ctl_write(32'h0002_0015);
        chk("R2", "ctl_rdata hold+level", ctl_rdata, 32'h0002_0015);
        ctl_write(32'h0);
        chk("R2", "ctl_rdata zero", ctl_rdata, 32'h0);

        // R4 R5 sweep every count against every watermark
        for (int n = 0; n <= 16; n++) begin
            for (int l = 0; l < 32; l++) begin
                ctl_write(32'(l));
                chk("R5", $sformatf("trig n=%0d lvl=%0d", n, l), 32'(trig), 32'(n < l));
            end
            status("R4", n);
            if (n < 16) push(8'(8'h30 + n));
        end

        // R9 write while full is dropped
        push(8'hEE);
        status("R9", 16);
        chk("R9", "overflow set", 32'(overflow), 1);

        // R3 drain in order; R9 flag stays
        for (int i = 0; i < 16; i++) begin
            pop("R3", 8'(8'h30 + i));
            status("R3", 15 - i);
        end
        chk("R9", "overflow sticky", 32'(overflow), 1);

        // R10 read while empty
        pop("R10", 8'h00);
        status("R10", 0);
        chk("R10", "underflow set", 32'(underflow), 1);
        push(8'h01);
        pop("R10", 8'h01);
        chk("R10", "underflow sticky", 32'(underflow), 1);

        // R6 held flush
        for (int i = 0; i < 5; i++) push(8'(8'h40 + i));
        status("R6", 5);
        ctl_write(32'h0001_0000);
        for (int i = 0; i < 4; i++) begin
            push(8'(8'h50 + i));
            status("R6", 0);
        end
        chk("R6", "overflow cleared", 32'(overflow), 0);
        chk("R6", "underflow cleared", 32'(underflow), 0);

        // R7 release and resume, then one-shot flush
        ctl_write(32'h0);
        status("R7", 0);
        push(8'h61); push(8'h62); push(8'h63);
        ctl_write(32'h0001_0000);
        ctl_write(32'h0);
        status("R7", 0);
        push(8'h55);
        status("R7", 1);
        pop("R7", 8'h55);
        status("R7", 0);

        // R8 hold mode
        push(8'h11); push(8'h22);
        ctl_write(32'h0002_0000);
        for (int i = 0; i < 3; i++) begin
            pop("R8", 8'h11);
            status("R8", 2);
        end
        ctl_write(32'h0);
        pop("R8", 8'h11);
        pop("R8", 8'h22);
        status("R8", 0);

        // R11 simultaneous push and pop
        push(8'hA1); push(8'hA2);
        wr_en = 1'b1; wr_data = 8'hA3; rd_en = 1'b1;
        #1;
        chk("R11", "rd_data", 32'(rd_data), 32'hA1);
        step();
        wr_en = 1'b0; rd_en = 1'b0;
        status("R11", 2);
        pop("R11", 8'hA2);
        pop("R11", 8'hA3);
        status("R11", 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule